// File: doc/BRIEF.md
# Interrupt Sequencer with Return Stack

This unit decides, for a small 4-bit microcontroller core, when an instruction boundary turns into an interrupt entry. Each cycle it compares the request flags raised by the peripherals with a 4-bit enable register that instructions write. An interrupt is taken only when the core retires an instruction, at least one enabled request is pending, and the guard window that follows any newly set enable bit has run out. Taking an interrupt clears the whole enable register in hardware. The request flags are inputs owned by the peripherals and are never cleared here, so software must clear a flag before it enables interrupts again.

The unit also holds an eight-entry return-address stack. Interrupt entries and subroutine calls push onto it, and returns pop from it. A push onto a full stack raises a sticky overflow flag. The unit also holds the core's HALT and STOP low-power modes, and releases either one only when a pending request meets a set enable bit.

Top module: `intr_seq`

## Requirements
- R1: After reset the enable register is 0, the stack is empty (depth 0, top 0), the overflow flag is 0, neither HALT nor STOP is indicated, and no interrupt is signalled.
- R2: A write stores the 4-bit enable value on the next clock edge. A taken interrupt clears the whole enable register to 0 on the following edge, and this clear wins over a write in the same cycle.
- R3: `take_o` is high in the same cycle as `retire_i` only when (request AND enable) is non-zero, the guard window has expired, and the core is running. Without `retire_i` it stays low.
- R4: A write that sets any enable bit that was 0 blocks the next two retires. The third retire after the write may take an interrupt. A write that sets no new bit does not restart the window.
- R5: When several enabled requests are pending, the lowest-numbered source wins, and `vec_o` = VEC_BASE + index × VEC_STEP (defaults give 1 for source 0 up to 4 for source 3).
- R6: A taken interrupt or `call_i` pushes `ret_pc_i`, and `ret_i` pops. `top_o` shows the most recently pushed address (0 when empty), and `depth_o` gives the entry count, in last-in-first-out order.
- R7: A return leaves the enable register unchanged.
- R8: A push at depth 8 sets `ovf_o`, which stays set until reset. The depth and the stored addresses are left unchanged. A pop at depth 0 leaves the depth at 0.
- R9: `sleep_i` while running enters HALT (`sleep_stop_i`=0) or STOP (`sleep_stop_i`=1), shown on `halt_o` or `stop_o`. The mode holds while (request AND enable) is zero. When it becomes non-zero, `wake_o` is high in that cycle and the core is running from the next edge.
- R10: A push and a pop in the same cycle perform only the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request flag per source |
| ie_wr_i | input | 1 | Enable register write strobe |
| ie_wdata_i | input | 4 | Enable register write value |
| retire_i | input | 1 | Instruction retire strobe |
| ret_pc_i | input | 12 | Return address to push |
| call_i | input | 1 | Subroutine call push |
| ret_i | input | 1 | Return pop |
| sleep_i | input | 1 | Enter low-power mode |
| sleep_stop_i | input | 1 | 1 selects STOP, 0 selects HALT |
| take_o | output | 1 | Interrupt taken at this retire |
| vec_o | output | 12 | Vector of the winning source |
| ie_o | output | 4 | Current enable register |
| top_o | output | 12 | Top-of-stack address |
| depth_o | output | 4 | Stack entry count |
| ovf_o | output | 1 | Sticky stack overflow |
| halt_o | output | 1 | HALT mode active |
| stop_o | output | 1 | STOP mode active |
| wake_o | output | 1 | Low-power mode released this cycle |

## Verification
The hardest case to reach is the guard window while a request is already pending: a retire must be refused twice and accepted on the third. The stimulus clears the enable register, holds all four requests high, writes a single enable bit, and retires three times, sampling `take_o` at each retire. A separate sequence first opens the window, then writes a subset of the already-set bits, to show that the window does not restart. Overflow is reached by nine calls with no returns in between.

// File: rtl/intr_pkg.sv
package intr_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HALT = 2'd1,
        MODE_STOP = 2'd2
    } pwr_mode_e;
endpackage

// File: rtl/ie_gate.sv
// Enable register plus post-enable guard counter.
module ie_gate #(
    parameter int N_SRC   = 4,
    parameter int BLOCK_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic             retire_i,
    input  logic             take_i,
    output logic [N_SRC-1:0] ie_o,
    output logic             open_o
);
    localparam int CNT_W = $clog2(BLOCK_N + 1);

    typedef struct packed {
        logic [N_SRC-1:0] ie;
        logic [CNT_W-1:0] cnt;
    } gate_t;

    gate_t st_d, st_q;
    logic [N_SRC-1:0] rises;

    always_comb begin
        st_d  = st_q;
        rises = wdata_i & ~st_q.ie;
        if (retire_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_i) begin
            st_d.ie = wdata_i;
            if (|rises) begin
                st_d.cnt = CNT_W'(BLOCK_N);
            end
        end
        if (take_i) begin
            st_d.ie = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ie_o   = st_q.ie;
    assign open_o = (st_q.cnt == '0);

    AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (ie_o == '0)); // R2
endmodule

// File: rtl/prio_pick.sv
// Lowest-index winner among pending enabled sources, and its vector.
module prio_pick #(
    parameter int N_SRC    = 4,
    parameter int ADDR_W   = 12,
    parameter int VEC_BASE = 1,
    parameter int VEC_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  pend_i,
    output logic [N_SRC-1:0]  grant_o,
    output logic              any_o,
    output logic [ADDR_W-1:0] vec_o
);
    logic [N_SRC:0] seen;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N_SRC; g++) begin : g_chain
        assign grant_o[g]  = pend_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | pend_i[g];
    end
    assign any_o = seen[N_SRC];

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant_o[i]) begin
                vec_o = ADDR_W'(VEC_BASE + i * VEC_STEP);
            end
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R5
    AST_WINNER_IF_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i != '0) |-> ($countones(grant_o) == 1)); // R5
endmodule

// File: rtl/ret_stack.sv
// Return-address stack with sticky overflow.
module ret_stack #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [ADDR_W-1:0]          din_i,
    output logic [ADDR_W-1:0]          top_o,
    output logic [$clog2(DEPTH+1)-1:0] depth_o,
    output logic                       ovf_o
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [PTR_W-1:0]             ptr;
        logic                         ovf;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] top_ptr;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            if (st_q.ptr == PTR_W'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.mem[st_q.ptr[IDX_W-1:0]] = din_i;
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end else if (pop_i && st_q.ptr != '0) begin
            st_d.ptr = st_q.ptr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_ptr = st_q.ptr - 1'b1;
    assign top_o   = (st_q.ptr == '0) ? '0 : st_q.mem[top_ptr[IDX_W-1:0]];
    assign depth_o = st_q.ptr;
    assign ovf_o   = st_q.ovf;

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= PTR_W'(DEPTH)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R8
    AST_FULL_PUSH_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && depth_o == PTR_W'(DEPTH)) |=> (ovf_o && depth_o == PTR_W'(DEPTH))); // R8
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && depth_o != PTR_W'(DEPTH)) |=> (depth_o == $past(depth_o) + 1'b1)); // R10
endmodule

// File: rtl/intr_seq.sv
module intr_seq #(
    parameter int N_SRC    = 4,
    parameter int ADDR_W   = 12,
    parameter int DEPTH    = 8,
    parameter int BLOCK_N  = 2,
    parameter int VEC_BASE = 1,
    parameter int VEC_STEP = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC-1:0]           req_i,
    input  logic                       ie_wr_i,
    input  logic [N_SRC-1:0]           ie_wdata_i,
    input  logic                       retire_i,
    input  logic [ADDR_W-1:0]          ret_pc_i,
    input  logic                       call_i,
    input  logic                       ret_i,
    input  logic                       sleep_i,
    input  logic                       sleep_stop_i,
    output logic                       take_o,
    output logic [ADDR_W-1:0]          vec_o,
    output logic [N_SRC-1:0]           ie_o,
    output logic [ADDR_W-1:0]          top_o,
    output logic [$clog2(DEPTH+1)-1:0] depth_o,
    output logic                       ovf_o,
    output logic                       halt_o,
    output logic                       stop_o,
    output logic                       wake_o
);
    import intr_pkg::*;

    typedef struct packed {
        pwr_mode_e mode;
    } seq_t;

    seq_t st_d, st_q;

    logic [N_SRC-1:0] ie;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] grant;
    logic             any_pend;
    logic             gate_open;
    logic             push;
    logic             running;

    ie_gate #(.N_SRC(N_SRC), .BLOCK_N(BLOCK_N)) i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ie_wr_i),
        .wdata_i  (ie_wdata_i),
        .retire_i (retire_i),
        .take_i   (take_o),
        .ie_o     (ie),
        .open_o   (gate_open)
    );

    assign pend = req_i & ie;

    prio_pick #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend),
        .grant_o (grant),
        .any_o   (any_pend),
        .vec_o   (vec_o)
    );

    assign running = (st_q.mode == MODE_RUN);
    assign take_o  = retire_i && any_pend && gate_open && running;
    assign push    = take_o || call_i;

    ret_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (ret_i),
        .din_i   (ret_pc_i),
        .top_o   (top_o),
        .depth_o (depth_o),
        .ovf_o   (ovf_o)
    );

    always_comb begin
        st_d   = st_q;
        wake_o = 1'b0;
        if (running) begin
            if (sleep_i) begin
                st_d.mode = sleep_stop_i ? MODE_STOP : MODE_HALT;
            end
        end else if (any_pend) begin
            wake_o    = 1'b1;
            st_d.mode = MODE_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RUN};
        end else begin
            st_q <= st_d;
        end
    end

    assign ie_o   = ie;
    assign halt_o = (st_q.mode == MODE_HALT);
    assign stop_o = (st_q.mode == MODE_STOP);

    AST_BLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_wr_i && |(ie_wdata_i & ~ie_o) && !take_o) |=> !take_o); // R4
    AST_RET_KEEPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !ie_wr_i && !take_o) |=> (ie_o == $past(ie_o))); // R7
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && (req_i & ie_o) == '0) |=> (halt_o == $past(halt_o) && stop_o == $past(stop_o))); // R9
    AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> (!halt_o && !stop_o)); // R9
    AST_NO_DUAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_o && stop_o)); // R9
endmodule

// File: tb/test_intr_seq.sv
module test_intr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic        ie_wr = 1'b0;
    logic [3:0]  ie_wdata = '0;
    logic        retire = 1'b0;
    logic [11:0] ret_pc = '0;
    logic        call = 1'b0;
    logic        ret = 1'b0;
    logic        sleep = 1'b0;
    logic        sleep_stop = 1'b0;
    logic        take;
    logic [11:0] vec;
    logic [3:0]  ie;
    logic [11:0] top;
    logic [3:0]  depth;
    logic        ovf;
    logic        halt;
    logic        stop;
    logic        wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intr_seq i_intr_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ie_wr_i(ie_wr), .ie_wdata_i(ie_wdata),
        .retire_i(retire), .ret_pc_i(ret_pc), .call_i(call), .ret_i(ret),
        .sleep_i(sleep), .sleep_stop_i(sleep_stop), .take_o(take), .vec_o(vec),
        .ie_o(ie), .top_o(top), .depth_o(depth), .ovf_o(ovf), .halt_o(halt),
        .stop_o(stop), .wake_o(wake)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ie(input logic [3:0] v);
        ie_wr = 1'b1;
        ie_wdata = v;
        tick();
        ie_wr = 1'b0;
    endtask

    task automatic do_retire(output logic tk, output logic [11:0] vc);
        retire = 1'b1;
        #1;
        tk = take;
        vc = vec;
        tick();
        retire = 1'b0;
    endtask

    function automatic int low_vec(input int p);
        for (int i = 0; i < 4; i++) begin
            if (p[i]) return 1 + i;
        end
        return 0;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic tk;
        logic [11:0] vc;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ie == 0, "R1 ie", ie, 0);
        chk(depth == 0 && top == 0, "R1 stack", depth, 0);
        chk(ovf == 0, "R1 ovf", ovf, 0);
        chk(!halt && !stop, "R1 mode", {halt, stop}, 0);
        retire = 1'b1; #1;
        chk(take == 0, "R1 take", take, 0);
        tick(); retire = 1'b0;

        // R2 R3 R5 R6 sweep over every enable and request pattern
        for (int v = 0; v < 16; v++) begin
            for (int r = 0; r < 16; r++) begin
                int p;
                req = '0;
                write_ie(4'(0));
                write_ie(4'(v));
                do_retire(tk, vc);
                chk(tk == 0, "R3 idle retire", tk, 0);
                do_retire(tk, vc);
                chk(tk == 0, "R3 idle retire", tk, 0);
                req = 4'(r);
                ret_pc = 12'(v * 16 + r);
                p = r & v;
                do_retire(tk, vc);
                chk(tk == (p != 0), "R3 take", tk, int'(p != 0));
                if (p != 0) chk(vc == 12'(low_vec(p)), "R5 vector", vc, low_vec(p));
                chk(ie == ((p != 0) ? 4'(0) : 4'(v)), "R2 ie after", ie, (p != 0) ? 0 : v);
                chk(depth == ((p != 0) ? 4'd1 : 4'd0), "R6 depth", depth, int'(p != 0));
                if (p != 0) begin
                    chk(top == 12'(v * 16 + r), "R6 top", top, v * 16 + r);
                    req = '0;
                    ret = 1'b1;
                    tick();
                    ret = 1'b0;
                    chk(depth == 0, "R6 pop", depth, 0);
                end
            end
        end

        // R4 guard window with request already pending
        req = '0;
        write_ie(4'h0);
        req = 4'hF;
        write_ie(4'h2);
        do_retire(tk, vc);
        chk(tk == 0, "R4 retire1", tk, 0);
        do_retire(tk, vc);
        chk(tk == 0, "R4 retire2", tk, 0);
        #1;
        chk(take == 0, "R3 no retire", take, 0);
        do_retire(tk, vc);
        chk(tk == 1, "R4 retire3", tk, 1);
        chk(vc == 12'd2, "R5 vector single", vc, 2);
        ret = 1'b1; tick(); ret = 1'b0;
        // R4 write with no newly set bit keeps window open
        req = '0;
        write_ie(4'h3);
        do_retire(tk, vc);
        do_retire(tk, vc);
        write_ie(4'h1);
        req = 4'h1;
        do_retire(tk, vc);
        chk(tk == 1, "R4 no restart", tk, 1);
        chk(vc == 12'd1, "R5 vector src0", vc, 1);
        req = '0;
        ret = 1'b1; tick(); ret = 1'b0;

        // R7 return keeps enable
        write_ie(4'h5);
        call = 1'b1; ret_pc = 12'h123; tick(); call = 1'b0;
        chk(depth == 1 && top == 12'h123, "R6 call push", top, 12'h123);
        ret = 1'b1; tick(); ret = 1'b0;
        chk(ie == 4'h5, "R7 ie kept", ie, 5);
        chk(depth == 0, "R6 ret pop", depth, 0);

        // R8 pop at empty
        ret = 1'b1; tick(); ret = 1'b0;
        chk(depth == 0, "R8 empty pop", depth, 0);

        // R10 simultaneous push and pop
        call = 1'b1; ret = 1'b1; ret_pc = 12'h055; tick(); call = 1'b0; ret = 1'b0;
        chk(depth == 1 && top == 12'h055, "R10 push wins", top, 12'h055);
        ret = 1'b1; tick(); ret = 1'b0;

        // R6 fill, R8 overflow
        for (int k = 0; k < 8; k++) begin
            call = 1'b1; ret_pc = 12'(12'h100 + k); tick(); call = 1'b0;
            chk(depth == 4'(k + 1), "R6 fill depth", depth, k + 1);
            chk(top == 12'(12'h100 + k), "R6 fill top", top, 12'h100 + k);
        end
        chk(ovf == 0, "R8 no ovf at 8", ovf, 0);
        call = 1'b1; ret_pc = 12'hABC; tick(); call = 1'b0;
        chk(ovf == 1, "R8 ovf set", ovf, 1);
        chk(depth == 8 && top == 12'h107, "R8 contents kept", top, 12'h107);
        for (int k = 7; k >= 0; k--) begin
            chk(top == 12'(12'h100 + k), "R6 lifo", top, 12'h100 + k);
            ret = 1'b1; tick(); ret = 1'b0;
        end
        chk(depth == 0, "R6 drained", depth, 0);
        chk(ovf == 1, "R8 sticky", ovf, 1);

        // R9 HALT and wake
        write_ie(4'h0);
        req = 4'hF;
        sleep = 1'b1; sleep_stop = 1'b0; tick(); sleep = 1'b0;
        chk(halt == 1 && stop == 0, "R9 halt entry", {halt, stop}, 2);
        tick(); tick();
        chk(halt == 1 && wake == 0, "R9 halt held", {halt, wake}, 2);
        ie_wr = 1'b1; ie_wdata = 4'h4; tick(); ie_wr = 1'b0;
        #1;
        chk(wake == 1, "R9 wake", wake, 1);
        tick();
        chk(halt == 0, "R9 running", halt, 0);
        req = '0;
        write_ie(4'h0);
        // R9 STOP and wake
        write_ie(4'h2);
        sleep = 1'b1; sleep_stop = 1'b1; tick(); sleep = 1'b0;
        chk(stop == 1 && halt == 0, "R9 stop entry", {halt, stop}, 1);
        req = 4'h1;
        tick();
        chk(stop == 1 && wake == 0, "R9 stop held", {stop, wake}, 2);
        req = 4'h2;
        #1;
        chk(wake == 1, "R9 stop wake", wake, 1);
        tick();
        chk(stop == 0, "R9 stop released", stop, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule